// File: doc/BRIEF.md
# Chip-Select External Memory Bus Timing Controller

This block drives one chip-select region of an asynchronous external memory, such as a NOR flash with a 16-bit data bus. A client inside the chip presents a word address, write data, a direction flag and a valid signal. The block then runs one complete access on the pins: address and active-low chip select, an active-low read or write strobe, and an output enable for the shared data bus. When the access ends it returns a one-cycle done pulse, and read data for a read.

Three programmable phases set the pin timing. The first is the setup delay from chip select to strobe. The second is the number of wait cycles the strobe is held. The third is the hold delay from strobe release to chip-select release. Setup and hold are counted in half bus-clock cycles. The strobe edges are launched on the falling clock edge, and address, chip select and output enable change on the rising edge. After a write, a programmable number of idle cycles keeps the next access back. A configuration port loads the four timing fields. Each access uses the values that were in force when it was accepted.

Top module: `ebc_ctrl`

## Requirements
- R1: After reset, chip select, read strobe and write strobe are high, the output enable and done are low and ready is high. The timing fields reset to their slowest values: setup code 3, wait code 15, hold code 3 and idle code 7.
- R2: A request is accepted on a rising edge where req_valid and req_ready are both high. Chip select goes low in the next cycle. The address and write data stay unchanged on the bus while chip select is low.
- R3: Setup code c (0 to 3) places the strobe's falling edge c+0.5 clock cycles after chip select falls, on a falling clock edge.
- R4: Wait code c sets W wait cycles: W=c for c≤5, W=c−1 for 6≤c≤13, and W=12 for c of 14 or 15. The strobe stays low for W+1 clock cycles.
- R5: Hold code c (0 to 3) places the rise of chip select c+0.5 clock cycles after the strobe rises. Chip select is low for setup+W+hold+2 cycles in total.
- R6: A read drives only rd_n, keeps the output enable low, and captures bus_din on the last rising edge before rd_n rises. The captured value is presented on rsp_rdata during done.
- R7: A write drives only we_n. It holds the output enable high for exactly the cycles in which chip select is low, and drives the request's write data on bus_dout.
- R8: rsp_done is high for exactly one cycle, the first cycle after chip select rises.
- R9: After a write with idle code I (0 to 7), ready stays low for I cycles after chip select rises. After a read, ready is high in the done cycle.
- R10: Ready is low while an access runs. A request presented while ready is low starts nothing.
- R11: When cfg_we is high at a rising edge, the timing fields are loaded. An access already running keeps the timing it was accepted with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load the timing fields |
| cfg_setup | input | 2 | Setup code (chip select to strobe) |
| cfg_wait | input | 4 | Wait code |
| cfg_hold | input | 2 | Hold code (strobe to chip-select release) |
| cfg_idle | input | 3 | Idle cycles after a write |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address (byte address bits 21..1) |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle end-of-access pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| bus_addr | output | ADDR_W | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe | output | 1 | Data bus output enable |
| bus_dout | output | DATA_W | Data driven during a write |
| bus_din | input | DATA_W | Data read from the bus |

## Verification
The bound checker watches the ordering rules on every edge. A strobe only appears inside the chip-select window, and both strobes are released before chip select rises. The output enable never shows during a read. Done follows the rise of chip select and lasts one cycle, and ready stays low during an access. The exact half-cycle positions of the strobe edges, the mapping of each code to cycles, the capture instant of read data, the idle gap after writes and the snapshot of configuration at acceptance can only be shown by the bench. Its reference model predicts every pin in both halves of every cycle across several configurations.

// File: rtl/ebc_pkg.sv
`timescale 1ns/1ps
package ebc_pkg;
  localparam int SETUP_W = 2;
  localparam int WAIT_W  = 4;
  localparam int HOLD_W  = 2;
  localparam int IDLE_W  = 3;
  localparam int MAX_WAIT = 12;
  // longest access: 3 + 12 + 3 + 2 cycles
  localparam int MAX_LEN = (2**SETUP_W - 1) + MAX_WAIT + (2**HOLD_W - 1) + 2;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  typedef struct packed {
    logic [SETUP_W-1:0] setup;
    logic [WAIT_W-1:0]  wt;
    logic [HOLD_W-1:0]  hold;
    logic [IDLE_W-1:0]  idle;
  } ebc_cfg_t;

  localparam ebc_cfg_t CFG_SLOW = '{setup: '1, wt: '1, hold: '1, idle: '1};

  // wait code -> wait cycles, monotonic, saturating at MAX_WAIT
  function automatic logic [CNT_W-1:0] wait_cycles(input logic [WAIT_W-1:0] code);
    logic [CNT_W-1:0] c;
    c = CNT_W'(code);
    if (code <= WAIT_W'(5))       return c;
    else if (code >= WAIT_W'(13)) return CNT_W'(MAX_WAIT);
    else                          return c - CNT_W'(1);
  endfunction

  // index of the last cycle with chip select low
  function automatic logic [CNT_W-1:0] last_cycle(input ebc_cfg_t cfg);
    return CNT_W'(cfg.setup) + wait_cycles(cfg.wt) + CNT_W'(cfg.hold) + CNT_W'(1);
  endfunction
endpackage

// File: rtl/ebc_cfg_reg.sv
`timescale 1ns/1ps
module ebc_cfg_reg
  import ebc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     we,
  input  ebc_cfg_t cfg_in,
  output ebc_cfg_t cfg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cfg_q <= CFG_SLOW;
    else if (we) cfg_q <= cfg_in;
  end
endmodule

// File: rtl/ebc_seq.sv
`timescale 1ns/1ps
module ebc_seq
  import ebc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     start_write,
  input  ebc_cfg_t cfg_in,
  output logic     ready,
  output logic     in_access,
  output logic     cur_write,
  output logic     strobe_win,
  output logic     capture,
  output logic     done
);
  typedef enum logic [1:0] {S_IDLE, S_ACC, S_GAP} seq_state_e;

  seq_state_e        state;
  ebc_cfg_t          cur;
  logic [CNT_W-1:0]  cnt;
  logic [IDLE_W-1:0] gcnt;
  logic [CNT_W-1:0]  s_c, sw_c, last_c;
  logic              at_last;

  always_comb begin
    s_c     = CNT_W'(cur.setup);
    sw_c    = s_c + wait_cycles(cur.wt);
    last_c  = last_cycle(cur);
    at_last = (state == S_ACC) && (cnt == last_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cur       <= CFG_SLOW;
      cnt       <= '0;
      gcnt      <= '0;
      cur_write <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= at_last;
      unique case (state)
        S_IDLE: if (start) begin
          state     <= S_ACC;
          cnt       <= '0;
          cur       <= cfg_in;
          cur_write <= start_write;
        end
        S_ACC: begin
          if (at_last) begin
            if (cur_write && (cur.idle != '0)) begin
              state <= S_GAP;
              gcnt  <= cur.idle;
            end else begin
              state <= S_IDLE;
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_GAP: begin
          if (gcnt == IDLE_W'(1)) state <= S_IDLE;
          else                    gcnt  <= gcnt - IDLE_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign ready      = (state == S_IDLE);
  assign in_access  = (state == S_ACC);
  assign strobe_win = in_access && (cnt >= s_c) && (cnt <= sw_c);
  assign capture    = in_access && !cur_write && (cnt == sw_c);
endmodule

// File: rtl/ebc_strobe.sv
`timescale 1ns/1ps
module ebc_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic win,
  input  logic wr,
  output logic rd_n,
  output logic we_n
);
  // falling-edge launch gives the half-cycle offsets
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_n <= 1'b1;
      we_n <= 1'b1;
    end else begin
      rd_n <= !(win && !wr);
      we_n <= !(win && wr);
    end
  end
endmodule

// File: rtl/ebc_ctrl.sv
`timescale 1ns/1ps
module ebc_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 21,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_setup,
  input  logic [3:0]        cfg_wait,
  input  logic [1:0]        cfg_hold,
  input  logic [2:0]        cfg_idle,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_cs_n,
  output logic              bus_rd_n,
  output logic              bus_we_n,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  input  logic [DATA_W-1:0] bus_din
);
  ebc_cfg_t cfg_new, cfg_q;
  logic     acc_start, in_access, cur_write, strobe_win, capture;

  assign cfg_new   = '{setup: cfg_setup, wt: cfg_wait, hold: cfg_hold, idle: cfg_idle};
  assign acc_start = req_valid && req_ready;

  ebc_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .cfg_in(cfg_new), .cfg_q(cfg_q)
  );

  ebc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(acc_start), .start_write(req_write),
    .cfg_in(cfg_q), .ready(req_ready), .in_access(in_access),
    .cur_write(cur_write), .strobe_win(strobe_win), .capture(capture),
    .done(rsp_done)
  );

  ebc_strobe u_stb (
    .clk(clk), .rst_n(rst_n), .win(strobe_win), .wr(cur_write),
    .rd_n(bus_rd_n), .we_n(bus_we_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_addr  <= '0;
      bus_dout  <= '0;
      rsp_rdata <= '0;
    end else begin
      if (acc_start) begin
        bus_addr <= req_addr;
        bus_dout <= req_wdata;
      end
      if (capture) rsp_rdata <= bus_din;
    end
  end

  assign bus_cs_n = !in_access;
  assign bus_oe   = in_access && cur_write;
endmodule

// File: rtl/ebc_ctrl_chk.sv
`timescale 1ns/1ps
module ebc_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic acc_start,
  input logic req_ready,
  input logic rsp_done,
  input logic bus_cs_n,
  input logic bus_rd_n,
  input logic bus_we_n,
  input logic bus_oe
);
  a_r2_cs_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !bus_cs_n);
  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd_n || !bus_we_n) |-> !bus_cs_n);
  a_r5_strobe_off_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> ($past(bus_rd_n) && $past(bus_we_n)));
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_we_n));
  a_r6_no_oe_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_oe);
  a_r7_oe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> !bus_cs_n);
  a_r8_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_cs_n) |-> rsp_done);
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);
  a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_cs_n |-> !req_ready);
endmodule

bind ebc_ctrl ebc_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .req_ready(req_ready),
  .rsp_done(rsp_done), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
  .bus_we_n(bus_we_n), .bus_oe(bus_oe)
);

// File: tb/test_ebc_ctrl.sv
`timescale 1ns/1ps
module test_ebc_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_setup = '0;
  logic [3:0]  cfg_wait = '0;
  logic [1:0]  cfg_hold = '0;
  logic [2:0]  cfg_idle = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [15:0] bus_din = '0;
  logic        req_ready, rsp_done, bus_cs_n, bus_rd_n, bus_we_n, bus_oe;
  logic [15:0] rsp_rdata, bus_dout;
  logic [20:0] bus_addr;

  ebc_ctrl i_ebc_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_setup(cfg_setup),
    .cfg_wait(cfg_wait), .cfg_hold(cfg_hold), .cfg_idle(cfg_idle),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_done(rsp_done),
    .rsp_rdata(rsp_rdata), .bus_addr(bus_addr), .bus_cs_n(bus_cs_n),
    .bus_rd_n(bus_rd_n), .bus_we_n(bus_we_n), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_din(bus_din)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    bit cs; bit oe; bit rd1; bit rd2; bit we1; bit we2;
    bit rdy; bit dn; bit chkrd; logic [15:0] rdv;
    logic [20:0] adr; bit wr; logic [15:0] wd;
  } rec_t;

  rec_t   q[$];
  int     nchk = 0, nerr = 0, cyc = 0, acc_count = 0;
  string  scen = "reset";
  int     m_setup = 3, m_wait = 15, m_hold = 3, m_idle = 7;
  bit     m_ready = 1'b1;

  function automatic logic [15:0] pat(input int c);
    return 16'(32'h5A3C + c * 32'h0F1D);
  endfunction

  always @(negedge clk) bus_din <= pat(cyc);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s [%s] cycle %0d: actual=%0h expected=%0h", tag, scen, cyc, act, exp);
    end
  endtask

  function automatic int waits(input int code);
    if (code >= 13) return 12;
    if (code >= 6)  return code - 1;
    return code;
  endfunction

  task automatic plan_access(input bit wr, input logic [20:0] a, input logic [15:0] d);
    int s, w, h, n, gap, len, st, en;
    s = m_setup; w = waits(m_wait); h = m_hold;
    n = s + w + h + 2;
    gap = wr ? m_idle : 0;
    len = n + ((gap > 1) ? gap : 1);
    st = 2 * s + 1;              // strobe start, in half cycles
    en = st + 2 * w + 2;         // strobe end, in half cycles
    for (int j = 0; j < len; j++) begin
      rec_t r;
      r = '0;
      r.cs  = (j < n);
      r.oe  = r.cs && wr;
      r.rd1 = !wr && (2*j >= st) && (2*j < en);
      r.rd2 = !wr && (2*j+1 >= st) && (2*j+1 < en);
      r.we1 = wr && (2*j >= st) && (2*j < en);
      r.we2 = wr && (2*j+1 >= st) && (2*j+1 < en);
      r.dn  = (j == n);
      r.rdy = (j >= n) && !(wr && (j < n + gap));
      r.chkrd = r.dn && !wr;
      r.rdv = pat(cyc + s + w);
      r.adr = a; r.wr = wr; r.wd = d;
      q.push_back(r);
    end
  endtask

  // reference model, compared in both halves of every cycle
  initial begin
    forever begin
      rec_t r;
      @(posedge clk);
      cyc++;
      if (!rst_n) continue;
      if (req_valid && m_ready) begin
        plan_access(req_write, req_addr, req_wdata);
        acc_count++;
      end
      if (cfg_we) begin
        m_setup = cfg_setup; m_wait = cfg_wait; m_hold = cfg_hold; m_idle = cfg_idle;
      end
      if (q.size() != 0) r = q.pop_front();
      else begin
        r = '0; r.rdy = 1'b1;
      end
      m_ready = r.rdy;
      #5;
      chk(bus_cs_n === !r.cs, "R2 R5 cs", bus_cs_n, !r.cs);
      chk(bus_oe === r.oe, "R7 oe", bus_oe, r.oe);
      chk(req_ready === r.rdy, "R9 R10 ready", req_ready, r.rdy);
      chk(rsp_done === r.dn, "R8 done", rsp_done, r.dn);
      chk(bus_rd_n === !r.rd1, "R3 R4 R6 rd first half", bus_rd_n, !r.rd1);
      chk(bus_we_n === !r.we1, "R3 R4 R7 we first half", bus_we_n, !r.we1);
      if (r.cs) chk(bus_addr === r.adr, "R2 addr", bus_addr, r.adr);
      if (r.cs && r.wr) chk(bus_dout === r.wd, "R7 dout", bus_dout, r.wd);
      if (r.chkrd) chk(rsp_rdata === r.rdv, "R6 rdata", rsp_rdata, r.rdv);
      #10;
      chk(bus_rd_n === !r.rd2, "R3 R5 R6 rd second half", bus_rd_n, !r.rd2);
      chk(bus_we_n === !r.we2, "R3 R5 R7 we second half", bus_we_n, !r.we2);
    end
  end

  task automatic do_req(input bit wr, input logic [20:0] a, input logic [15:0] d);
    int base;
    @(negedge clk);
    base = acc_count;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do @(negedge clk); while (acc_count == base);
    req_valid = 1'b0;
  endtask

  task automatic set_cfg(input logic [1:0] s, input logic [3:0] w, input logic [1:0] h, input logic [2:0] i);
    @(negedge clk);
    cfg_setup = s; cfg_wait = w; cfg_hold = h; cfg_idle = i; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (q.size() != 0);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    #3_000_000;
    nchk++; nerr++;
    $display("FAIL watchdog [%s]: actual=hung expected=finished", scen);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #5;
    // R1: idle pin state after reset
    chk(bus_cs_n === 1'b1 && bus_rd_n === 1'b1 && bus_we_n === 1'b1, "R1 strobes idle",
        {bus_cs_n, bus_rd_n, bus_we_n}, 3'b111);
    chk(bus_oe === 1'b0 && rsp_done === 1'b0, "R1 oe done low", {bus_oe, rsp_done}, 2'b00);
    chk(req_ready === 1'b1, "R1 ready high", req_ready, 1'b1);

    scen = "R1 slowest defaults";
    do_req(1'b0, 21'h1ABCD, 16'h0);
    do_req(1'b1, 21'h00F0F, 16'hBEEF);
    wait_idle();

    scen = "R3 R4 R5 1.5/5/1.5 back-to-back R9";
    set_cfg(2'b01, 4'b0110, 2'b01, 3'b001);
    do_req(1'b1, 21'h12345, 16'h1234);
    do_req(1'b0, 21'h12345, 16'h0);
    do_req(1'b0, 21'h00001, 16'h0);
    wait_idle();

    scen = "R4 minimum timing, idle 0";
    set_cfg(2'b00, 4'b0000, 2'b00, 3'b000);
    do_req(1'b1, 21'h1FFFF, 16'hA5A5);
    do_req(1'b1, 21'h00002, 16'h5A5A);
    do_req(1'b0, 21'h10000, 16'h0);
    wait_idle();

    scen = "R4 saturated wait, R9 idle 5";
    set_cfg(2'b10, 4'b1110, 2'b11, 3'b101);
    do_req(1'b0, 21'h0AAAA, 16'h0);
    do_req(1'b1, 21'h15555, 16'hC3C3);
    do_req(1'b0, 21'h0AAAA, 16'h0);
    wait_idle();

    scen = "R4 wait codes 7 and 13";
    set_cfg(2'b11, 4'b0111, 2'b00, 3'b010);
    do_req(1'b0, 21'h00100, 16'h0);
    set_cfg(2'b00, 4'b1101, 2'b10, 3'b011);
    do_req(1'b1, 21'h00200, 16'h7E7E);
    wait_idle();

    // R10: a pulse of valid while ready is low must start nothing
    scen = "R10 request while busy";
    set_cfg(2'b01, 4'b0011, 2'b01, 3'b100);
    do_req(1'b1, 21'h03030, 16'h3030);
    repeat (4) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 21'h1DEAD;
    @(negedge clk);
    req_valid = 1'b0;
    wait_idle();
    chk(bus_cs_n === 1'b1, "R10 no access started", bus_cs_n, 1'b1);

    // R11: configuration loaded during an access applies to the next one only
    scen = "R11 config during access";
    set_cfg(2'b11, 4'b1010, 2'b11, 3'b000);
    do_req(1'b0, 21'h04444, 16'h0);
    set_cfg(2'b00, 4'b0001, 2'b00, 3'b001);
    wait_idle();
    do_req(1'b1, 21'h05555, 16'h9999);
    do_req(1'b0, 21'h05555, 16'h0);
    wait_idle();

    summary();
    $finish;
  end
endmodule